// File: doc/BRIEF.md
# Byte-wide SPI Controller with Master and Slave Modes

This block moves one byte at a time over a four-wire synchronous serial link. A processor drives it through three byte registers: control, status and data. As a master it generates the serial clock from the system clock and shifts a byte out on `mosi_o` while it shifts a byte in from `miso_i`. As a slave it follows an external serial clock. A select input, active low, gates it. It shifts in from `mosi_i` and drives `miso_o`. Software sets the clock idle level and the sampling phase.

Received bytes land in a read buffer that the data register returns. The next byte can arrive while software still holds the last one. Transmit data goes straight into the shift register and has no buffer. A data write that arrives while a byte is moving is therefore discarded and flagged. A completion flag marks each finished byte and can raise an interrupt. Software clears both flags in two steps: it reads the status register, then it accesses the data register.

Top module: `spi_port`

## Requirements
- R1: After reset the control register and the status register read 0, and `sck_o`, `irq_o`, `mosi_o` and `miso_o` are all 0.
- R2: Register map (`addr_i`): 0 is control, 1 is status, 2 is data. Control bits: 7 interrupt enable, 6 enable, 4 master, 3 clock polarity, 2 clock phase.
- R3: In master mode with enable set, a data write starts exactly 16 transitions of `sck_o`, one every 2 system clocks. Afterwards `sck_o` rests at the polarity bit. While idle it always shows that bit.
- R4: Bits move MSB first. With phase 0 the input is sampled on the first clock edge of each bit (away from idle). With phase 1 it is sampled on the second edge. The output bit changes on the other edge.
- R5: When the eighth bit has been sampled, the received byte is copied to the read buffer and status bit 7 (complete) is set. Data register reads return the buffer.
- R6: A data write while a transfer is active (master: clock burst running; slave: enabled and selected) is ignored. It leaves the byte in flight unchanged and sets status bit 6 (collision).
- R7: A status read that sees either flag set, followed by a read or write of the data register, clears both flags. A flag set in the same cycle as the clearing access stays set.
- R8: `irq_o` is high exactly while status bit 7 and the interrupt-enable bit are both 1.
- R9: In slave mode, clock edges count only while `ss_ni` is low. Raising `ss_ni` mid-byte drops the partial byte without setting a flag.
- R10: In slave mode, a data write made while unselected preloads the shift register. The master's clock train then shifts that byte out on `miso_o`, MSB first.
- R11: With the enable bit clear, a data write starts no clock and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (reads have side effects) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock out (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| ss_ni | input | 1 | Slave select, active low |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_i | input | 1 | Serial data in for master mode |

## Verification
Completion of a byte and the clearing data access of the flag-clear sequence can land on the same clock edge. To provoke this, a master transfer with phase 0 is started, and a write during the burst raises the collision flag. A status read then arms the clear. A data read is placed on the exact edge where the eighth bit is sampled, two system clocks before the burst ends. The outcome is judged by reading status afterwards: the collision flag must be gone, the completion flag must be set, and the buffer must hold the byte that was first written, unaffected by the dropped write.

// File: rtl/spi_pkg.sv
`timescale 1ns/1ps
package spi_pkg;
  localparam int DW    = 8;            // byte width
  localparam int CW    = $clog2(DW);   // bit counter width
  localparam int EDGES = 2 * DW;       // sck transitions per byte
  localparam int EW    = $clog2(EDGES);

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_sel_e;

  localparam int B_IE   = 7;
  localparam int B_EN   = 6;
  localparam int B_MST  = 4;
  localparam int B_CPOL = 3;
  localparam int B_CPHA = 2;
  localparam int B_DONE = 7;
  localparam int B_WCOL = 6;
endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
  parameter int           W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      s2_q <= RST;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spi_sck_gen.sv
`timescale 1ns/1ps
module spi_sck_gen
  import spi_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cpol_i,
  output logic run_o,
  output logic lead_o,
  output logic trail_o,
  output logic sck_o
);
  logic          run_q, ph_q, sck_q;
  logic [EW-1:0] ecnt_q;
  logic          tick;

  // one sck transition every second system clock: fixed divide-by-4
  assign tick = run_q & ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ph_q   <= 1'b0;
      sck_q  <= 1'b0;
      ecnt_q <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      ph_q   <= 1'b0;
      ecnt_q <= '0;
      sck_q  <= cpol_i;
    end else if (run_q) begin
      ph_q <= ~ph_q;
      if (ph_q) begin
        sck_q  <= ~sck_q;
        ecnt_q <= ecnt_q + EW'(1);
        if (ecnt_q == EW'(EDGES - 1)) run_q <= 1'b0;
      end
    end else begin
      sck_q <= cpol_i;
    end
  end

  assign run_o   = run_q;
  assign lead_o  = tick & ~ecnt_q[0];
  assign trail_o = tick &  ecnt_q[0];
  assign sck_o   = sck_q;
endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port
  import spi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          sck_o,
  input  logic          sck_i,
  input  logic          ss_ni,
  output logic          mosi_o,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          miso_i
);
  logic ie_q, en_q, mst_q, cpol_q, cpha_q;
  logic wr_ctrl, wr_data, rd_stat, rd_data;

  assign wr_ctrl = wr_i && (addr_i == REG_CTRL);
  assign wr_data = wr_i && (addr_i == REG_DATA);
  assign rd_stat = rd_i && (addr_i == REG_STAT);
  assign rd_data = rd_i && (addr_i == REG_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q <= 1'b0; en_q <= 1'b0; mst_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0;
    end else if (wr_ctrl) begin
      ie_q   <= wdata_i[B_IE];
      en_q   <= wdata_i[B_EN];
      mst_q  <= wdata_i[B_MST];
      cpol_q <= wdata_i[B_CPOL];
      cpha_q <= wdata_i[B_CPHA];
    end
  end

  // slave pins: {sck, ss_n, mosi}
  logic [2:0] sync_q;
  logic       sck_s, ss_s, mosi_s;

  spi_sync #(.W(3), .RST(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ss_ni, mosi_i}),
    .q_o   (sync_q)
  );
  assign sck_s  = sync_q[2];
  assign ss_s   = sync_q[1];
  assign mosi_s = sync_q[0];

  logic slv_sel, mst_run, busy, start, sload, coll;
  logic g_lead, g_trail, g_sck;

  assign slv_sel = en_q & ~mst_q & ~ss_s;
  assign busy    = mst_run | slv_sel;
  assign start   = wr_data & en_q &  mst_q & ~busy;
  assign sload   = wr_data & en_q & ~mst_q & ~busy;
  assign coll    = wr_data & en_q & busy;

  spi_sck_gen u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .cpol_i (cpol_q),
    .run_o  (mst_run),
    .lead_o (g_lead),
    .trail_o(g_trail),
    .sck_o  (g_sck)
  );

  logic sck_prev_q, s_edge, s_lead, s_trail;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_prev_q <= 1'b0;
    else         sck_prev_q <= sck_s;
  end
  assign s_edge  = slv_sel & (sck_s ^ sck_prev_q);
  assign s_lead  = s_edge & (sck_prev_q == cpol_q);
  assign s_trail = s_edge & (sck_prev_q != cpol_q);

  logic lead, trail, smp, drv, din;
  assign lead  = mst_q ? g_lead  : s_lead;
  assign trail = mst_q ? g_trail : s_trail;
  assign smp   = cpha_q ? trail : lead;
  assign drv   = cpha_q ? lead  : trail;
  assign din   = mst_q ? miso_i : mosi_s;

  logic [DW-1:0] sh_q, rbuf_q;
  logic [CW-1:0] bit_cnt;
  logic          out_q, done_q, wcol_q, armed_q, done_evt, clr;

  assign done_evt = smp && (bit_cnt == CW'(DW - 1));
  assign clr      = armed_q & (wr_data | rd_data);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      out_q   <= 1'b0;
      bit_cnt <= '0;
      rbuf_q  <= '0;
    end else begin
      if (start || sload)  sh_q <= wdata_i;
      else if (smp)        sh_q <= {sh_q[DW-2:0], din};

      if (start || sload)  out_q <= wdata_i[DW-1];
      else if (drv)        out_q <= sh_q[DW-1];

      if (start || (!mst_q && !slv_sel)) bit_cnt <= '0;
      else if (smp)                      bit_cnt <= bit_cnt + CW'(1);

      if (done_evt) rbuf_q <= {sh_q[DW-2:0], din};
    end
  end

  // flag set beats a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      wcol_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (done_evt) done_q <= 1'b1;
      else if (clr) done_q <= 1'b0;

      if (coll)     wcol_q <= 1'b1;
      else if (clr) wcol_q <= 1'b0;

      if (rd_stat && (done_q || wcol_q)) armed_q <= 1'b1;
      else if (wr_data || rd_data)       armed_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (reg_sel_e'(addr_i))
      REG_CTRL: begin
        rdata_o[B_IE]   = ie_q;
        rdata_o[B_EN]   = en_q;
        rdata_o[B_MST]  = mst_q;
        rdata_o[B_CPOL] = cpol_q;
        rdata_o[B_CPHA] = cpha_q;
      end
      REG_STAT: begin
        rdata_o[B_DONE] = done_q;
        rdata_o[B_WCOL] = wcol_q;
      end
      REG_DATA: rdata_o = rbuf_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o  = ie_q & done_q;
  assign sck_o  = g_sck;
  assign mosi_o =  mst_q & out_q;
  assign miso_o = ~mst_q & out_q;
endmodule

// File: rtl/spi_port_chk.sv
`timescale 1ns/1ps
module spi_port_chk
  import spi_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    addr_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic          irq_o,
  input logic          sck_o,
  input logic          mst_run,
  input logic          done_evt,
  input logic          done_q,
  input logic          wcol_q,
  input logic          en_q,
  input logic          mst_q,
  input logic          cpol_q,
  input logic          ss_s,
  input logic [CW-1:0] bit_cnt
);
  logic [EW:0] tcnt_q;
  logic        sck_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q  <= '0;
      sck_d_q <= 1'b0;
    end else begin
      sck_d_q <= sck_o;
      if (!mst_run)             tcnt_q <= '0;
      else if (sck_o != sck_d_q) tcnt_q <= tcnt_q + (EW+1)'(1);
    end
  end

  // R3
  sck_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mst_run) |-> (tcnt_q + (EW+1)'(sck_o != sck_d_q)) == (EW+1)'(EDGES));

  // R3
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mst_run && $past(!mst_run) && $stable(cpol_q) && $past(cpol_q, 2) == cpol_q)
      |-> $stable(sck_o));

  // R6
  wcol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_DATA && mst_run && en_q) |=> wcol_q);

  // R7
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(done_q) || $fell(wcol_q)) |-> $past(addr_i == REG_DATA && (rd_i || wr_i)));

  // R8
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(done_evt) || $past(wr_i && addr_i == REG_CTRL)));

  // R9
  slv_unsel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mst_q && ss_s) |=> (bit_cnt == '0));
endmodule

bind spi_port spi_port_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .irq_o   (irq_o),
  .sck_o   (sck_o),
  .mst_run (mst_run),
  .done_evt(done_evt),
  .done_q  (done_q),
  .wcol_q  (wcol_q),
  .en_q    (en_q),
  .mst_q   (mst_q),
  .cpol_q  (cpol_q),
  .ss_s    (ss_s),
  .bit_cnt (bit_cnt)
);

// File: tb/sim_spi_port.sv
`timescale 1ns/1ps
module sim_spi_port;
  import spi_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       irq, sck_o, mosi_o, miso_o, miso_i;
  logic       sck_i = 1'b0, ss_n = 1'b1, mosi_i = 1'b0;
  logic       inv = 1'b0;

  int errs = 0, checks = 0, tog = 0;
  logic sck_last = 1'b0;
  logic cpol_cur = 1'b0, cpha_cur = 1'b0;

  always #5 clk = ~clk;

  assign miso_i = mosi_o ^ inv;  // bench-side slave: echo, optionally inverted

  spi_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sck_o(sck_o),
    .sck_i(sck_i), .ss_ni(ss_n), .mosi_o(mosi_o), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_i(miso_i)
  );

  always @(negedge clk) begin
    if (sck_o !== sck_last) tog++;
    sck_last = sck_o;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  function automatic logic [7:0] cval(logic ie, logic en, logic mst, logic cpol, logic cpha);
    return {ie, en, 1'b0, mst, cpol, cpha, 2'b00};
  endfunction

  task automatic set_ctrl(input logic ie, input logic en, input logic mst,
                          input logic cpol, input logic cpha);
    cpu_wr(REG_CTRL, cval(ie, en, mst, cpol, cpha));
    cpol_cur = cpol;
    cpha_cur = cpha;
    repeat (2) @(negedge clk);
  endtask

  task automatic m_xfer(input logic [7:0] d, input logic iv, input logic ie);
    logic [7:0] s, r;
    int base;
    inv = iv;
    #1 base = tog;
    cpu_wr(REG_DATA, d);
    repeat (40) @(negedge clk);
    #1;
    chk("R3 sck transitions", tog - base, 16);
    chk("R3 sck idle level", sck_o, cpol_cur);
    chk("R8 irq while complete", irq, ie);
    cpu_rd(REG_STAT, s);
    chk("R5 complete flag", s, 8'h80);
    cpu_rd(REG_DATA, r);
    chk("R4 R5 master rx byte", r, d ^ {8{iv}});
    cpu_rd(REG_STAT, s);
    chk("R7 flags cleared", s, 8'h00);
    chk("R8 irq low after clear", irq, 1'b0);
  endtask

  task automatic s_xfer(input logic [7:0] mb, input logic [7:0] sb, input int coll_bit);
    logic [7:0] cap, s, r;
    cap = '0;
    ss_n = 1'b1; sck_i = cpol_cur;
    cpu_wr(REG_DATA, sb);
    repeat (4) @(negedge clk);
    ss_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      if (!cpha_cur) begin
        mosi_i = mb[i];
        if (coll_bit == i) begin cpu_wr(REG_DATA, ~sb); repeat (6) @(negedge clk); end
        else repeat (8) @(negedge clk);
        cap[i] = miso_o;
        sck_i = ~cpol_cur;
        repeat (8) @(negedge clk);
        sck_i = cpol_cur;
      end else begin
        sck_i = ~cpol_cur; mosi_i = mb[i];
        repeat (8) @(negedge clk);
        cap[i] = miso_o;
        sck_i = cpol_cur;
        if (coll_bit == i) begin cpu_wr(REG_DATA, ~sb); repeat (6) @(negedge clk); end
        else repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    ss_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R10 R4 slave miso byte", cap, sb);
    cpu_rd(REG_STAT, s);
    chk("R5 R6 slave status", s, (coll_bit >= 0) ? 8'hC0 : 8'h80);
    cpu_rd(REG_DATA, r);
    chk("R4 R5 slave rx byte", r, mb);
    cpu_rd(REG_STAT, s);
    chk("R7 slave flags cleared", s, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] s, r;
    int base;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    #1;
    chk("R1 sck_o", sck_o, 0);
    chk("R1 irq_o", irq, 0);
    chk("R1 mosi_o", mosi_o, 0);
    chk("R1 miso_o", miso_o, 0);
    cpu_rd(REG_CTRL, s); chk("R1 R2 control", s, 8'h00);
    cpu_rd(REG_STAT, s); chk("R1 R2 status", s, 8'h00);

    // R2 control readback
    cpu_wr(REG_CTRL, cval(1, 1, 1, 1, 1));
    cpu_rd(REG_CTRL, s); chk("R2 control readback", s, 8'hDC);

    // R11 disabled: no clock, no flag
    set_ctrl(0, 0, 1, 0, 0);
    #1 base = tog;
    cpu_wr(REG_DATA, 8'h55);
    repeat (40) @(negedge clk);
    #1 chk("R11 no sck when disabled", tog - base, 0);
    cpu_rd(REG_STAT, s); chk("R11 no flag when disabled", s, 8'h00);

    // directed master, every polarity/phase
    for (int m = 0; m < 4; m++) begin
      set_ctrl(1, 1, 1, m[1], m[0]);
      m_xfer(8'hA5 ^ 8'(m), m[0], 1);
    end

    // R6 collision during master burst, flag alone
    set_ctrl(0, 1, 1, 0, 1);
    inv = 1'b1;
    cpu_wr(REG_DATA, 8'h3E);
    for (int j = 1; j < 36; j++) begin
      @(negedge clk);
      wr = (j == 6); addr = REG_DATA; wdata = 8'hFF;
    end
    cpu_rd(REG_STAT, s); chk("R6 collision flag set", s, 8'hC0);
    cpu_rd(REG_DATA, r); chk("R6 transfer undisturbed", r, 8'h3E ^ 8'hFF);
    cpu_rd(REG_STAT, s); chk("R7 both flags cleared", s, 8'h00);

    // R7 clearing data read on the same edge as completion (phase 0: edge 30)
    set_ctrl(0, 1, 1, 0, 0);
    inv = 1'b0;
    cpu_wr(REG_DATA, 8'hA5);
    for (int j = 1; j < 32; j++) begin
      @(negedge clk);
      wr = (j == 4);
      rd = (j == 10) || (j == 29);
      addr = (j == 10) ? REG_STAT : REG_DATA;
      wdata = 8'h3C;
    end
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    repeat (10) @(negedge clk);
    cpu_rd(REG_STAT, s); chk("R7 set wins over coincident clear", s, 8'h80);
    cpu_rd(REG_DATA, r); chk("R6 R5 byte after clash", r, 8'hA5);

    // constrained random master
    for (int k = 0; k < 12; k++) begin
      logic [7:0] d;
      logic p, h, e, v;
      d = 8'($urandom); p = 1'($urandom); h = 1'($urandom);
      e = 1'($urandom); v = 1'($urandom);
      set_ctrl(e, 1, 1, p, h);
      m_xfer(d, v, e);
    end

    // R9 slave: clocks ignored while unselected, abort mid-byte
    set_ctrl(0, 1, 0, 0, 0);
    cpu_wr(REG_DATA, 8'h81);
    for (int i = 0; i < 10; i++) begin
      sck_i = ~sck_i; repeat (8) @(negedge clk);
    end
    sck_i = 1'b0;
    repeat (8) @(negedge clk);
    ss_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      sck_i = 1'b1; repeat (8) @(negedge clk);
      sck_i = 1'b0; repeat (8) @(negedge clk);
    end
    ss_n = 1'b1;
    repeat (8) @(negedge clk);
    cpu_rd(REG_STAT, s); chk("R9 no flag after abort or unselected clocks", s, 8'h00);
    s_xfer(8'hC3, 8'h5A, -1);

    // R10 directed slave in every mode, plus slave collision
    for (int m = 0; m < 4; m++) begin
      set_ctrl(0, 1, 0, m[1], m[0]);
      s_xfer(8'h96 ^ 8'(m), 8'h1E ^ 8'(m << 4), (m == 2) ? 3 : -1);
    end

    // constrained random slave
    for (int k = 0; k < 6; k++) begin
      logic [7:0] a, b;
      logic p, h;
      a = 8'($urandom); b = 8'($urandom); p = 1'($urandom); h = 1'($urandom);
      set_ctrl(0, 1, 0, p, h);
      s_xfer(a, b, (k == 1) ? 5 : -1);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule